// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the control state machine for a 10-bit successive-approximation converter. Software writes a control word with three fields: a converter-on bit, a start/busy bit and a 3-bit acquisition-time code. A valid start runs a fixed sequence. First comes an optional automatic acquisition period, during which the sample switch stays closed and the input is tracked. Next is one discharge period that clears the capacitor array. Last come ten bit trials, resolved from the most significant bit down. All timing is counted in conversion-clock periods, each marked by a single-cycle tick enable.

At the end of a conversion the block writes the result register, drops the busy bit, sets a sticky completion flag and closes the sample switch. Software can abort by writing the start bit low. An abort leaves the result register unchanged, whether it holds the last conversion or a value software wrote there. After every completion or abort, the block waits two tick periods before a pending start may begin a new sequence.

Top module: `sar_seq`

## Requirements
- R1: After a synchronous active-low reset, busy, done_flag, adc_on, discharge, dac_code and result are all zero, and sample_closed is 1.
- R2: The acquisition code sets the number of automatic acquisition ticks: 0→0, 1→2, 2→4, 3→6, 4→8, 5→12, 6→16, 7→20. During acquisition sample_closed is 1 and discharge is 0.
- R3: After acquisition, the conversion takes exactly 11 ticks: one discharge tick followed by ten bit-trial ticks. So a started conversion drops busy after (acquisition ticks + 11) ticks.
- R4: discharge is 1 for the single tick period right before the first bit trial, including when the acquisition time is zero. It is 0 otherwise.
- R5: sample_closed is 0 during discharge and bit trials, and 1 in every other phase.
- R6: At the tick that ends the bit-0 trial, result takes the converted code, busy clears, done_flag sets and sample_closed returns to 1. All of these are visible on the next clock cycle.
- R7: Writing the control word with go=0 while a sequence is running aborts it. After an abort, busy is 0 and result and done_flag keep their previous values.
- R8: After a completion or an abort, a pending start waits two ticks before the sequence begins. With acquisition code 0, discharge is still 0 after the first tick and becomes 1 only after the second.
- R9: A control write that sets go while the converter is currently off does not start a conversion: busy stays 0. Once the converter is on, a write with go=1 sets busy on the next cycle.
- R10: done_flag stays set until a flag_clr pulse clears it.
- R11: A software write to the result register (res_wr) replaces result, and a later abort preserves that value.
- R12: The sequence advances only on tad_tick. With no tick, the phase, discharge and dac_code hold.
- R13: During trial k (bits 9 down to 0), dac_code is the bits decided so far with bit k set. A bit is kept at 1 when cmp_in is 1 at its tick, meaning the input is at or above dac_code. Otherwise the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tad_tick | input | 1 | One-cycle conversion-clock tick enable |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_on | input | 1 | Converter-on value to write |
| ctl_go | input | 1 | Start/busy value to write |
| ctl_acq | input | 3 | Acquisition-time code to write |
| res_wr | input | 1 | Software write strobe for the result register |
| res_wdata | input | 10 | Software result value |
| flag_clr | input | 1 | Clears the completion flag |
| cmp_in | input | 1 | Comparator: 1 when input ≥ DAC level |
| dac_code | output | 10 | Trial code driven to the DAC |
| sample_closed | output | 1 | Sample switch closed (tracking) |
| discharge | output | 1 | Capacitor-array discharge control |
| adc_on | output | 1 | Converter-on readback |
| busy | output | 1 | Start/busy bit readback |
| done_flag | output | 1 | Sticky completion flag |
| result | output | 10 | Result register |

## Verification
Several internal faults show up at the ports within a few ticks. A wrong acquisition count or recovery count changes the tick on which discharge rises, and a phase that skips discharge shows as discharge never going high before the first trial. A trial register that keeps stale bits or checks the wrong bit position makes dac_code wrong on the second trial tick, and it also gives a result that differs from the comparator model's input at completion. Abort faults appear on the next cycle: either result changes or busy stays high.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_DISCH,
    ST_BITS,
    ST_RECOV
  } seq_state_t;

  localparam int unsigned MAX_ACQ_TICKS = 20;

  // Number of automatic acquisition ticks for each 3-bit code.
  function automatic int unsigned acq_len(input logic [2:0] code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 12;
      3'd6:    return 16;
      default: return 20;
    endcase
  endfunction

endpackage

// File: rtl/sar_ctrl_reg.sv
module sar_ctrl_reg #(
  parameter int ACQ_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_on,
  input  logic             wr_go,
  input  logic [ACQ_W-1:0] wr_acq,
  input  logic             clr_flag,
  input  logic             conv_active,
  input  logic             conv_end,
  output logic             adc_on,
  output logic             go,
  output logic [ACQ_W-1:0] acq_sel,
  output logic             done_flag,
  output logic             abort_evt
);

  // Abort: software drops go (or powers down) while a sequence runs.
  assign abort_evt = wr_ctrl & conv_active & ~(wr_on & wr_go);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adc_on    <= 1'b0;
      go        <= 1'b0;
      acq_sel   <= '0;
      done_flag <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        adc_on  <= wr_on;
        acq_sel <= wr_acq;
        // go may only be set when the converter was already on before this write
        go      <= wr_on & wr_go & adc_on;
      end else if (conv_end) begin
        go <= 1'b0;
      end
      if (conv_end)      done_flag <= 1'b1;
      else if (clr_flag) done_flag <= 1'b0;
    end
  end

  p_go_needs_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !adc_on) |=> !go);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !clr_flag) |=> done_flag);

endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
  import sar_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int ACQ_W       = 3,
  parameter int RECOV_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go,
  input  logic             adc_on,
  input  logic [ACQ_W-1:0] acq_sel,
  input  logic             abort_evt,
  output logic             sample_closed,
  output logic             discharge,
  output logic             bit_phase,
  output logic [$clog2(RES_W)-1:0] bit_idx,
  output logic             conv_end,
  output logic             conv_active
);

  localparam int IDX_W = $clog2(RES_W);
  localparam int CNT_MAX = (MAX_ACQ_TICKS > RECOV_TICKS) ? MAX_ACQ_TICKS : RECOV_TICKS;
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  seq_state_t       st;
  logic [CNT_W-1:0] cnt;

  assign sample_closed = (st == ST_IDLE) || (st == ST_ACQ) || (st == ST_RECOV);
  assign discharge     = (st == ST_DISCH);
  assign bit_phase     = (st == ST_BITS);
  assign conv_active   = (st == ST_ACQ) || (st == ST_DISCH) || (st == ST_BITS);
  assign conv_end      = bit_phase & tick & (bit_idx == '0) & ~abort_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
    end else if (conv_active && abort_evt) begin
      st  <= ST_RECOV;
      cnt <= CNT_W'(RECOV_TICKS - 1);
    end else begin
      case (st)
        ST_IDLE: if (go && adc_on) begin
          if (acq_len(acq_sel) == 0) st <= ST_DISCH;
          else begin
            st  <= ST_ACQ;
            cnt <= CNT_W'(acq_len(acq_sel) - 1);
          end
        end
        ST_ACQ: if (tick) begin
          if (cnt == '0) st <= ST_DISCH;
          else           cnt <= cnt - 1'b1;
        end
        ST_DISCH: if (tick) begin
          st      <= ST_BITS;
          bit_idx <= IDX_W'(RES_W - 1);
        end
        ST_BITS: if (tick) begin
          if (bit_idx == '0) begin
            st  <= ST_RECOV;
            cnt <= CNT_W'(RECOV_TICKS - 1);
          end else begin
            bit_idx <= bit_idx - 1'b1;
          end
        end
        ST_RECOV: if (tick) begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_bits_follow_disch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BITS && $past(st) != ST_BITS) |-> ($past(st) == ST_DISCH && $past(tick)));

  p_hold_without_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !abort_evt && st != ST_IDLE) |=> (st == $past(st)));

  p_recov_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) == ST_RECOV) |-> ($past(cnt) == '0 && $past(tick)));

endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int RES_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     cmp_in,
  input  logic                     discharge,
  input  logic                     bit_phase,
  input  logic [$clog2(RES_W)-1:0] bit_idx,
  input  logic                     conv_end,
  input  logic                     sw_wr,
  input  logic [RES_W-1:0]         sw_data,
  output logic [RES_W-1:0]         dac_code,
  output logic [RES_W-1:0]         result
);

  localparam int IDX_W = $clog2(RES_W);

  logic [RES_W-1:0] work;

  // Code presented to the DAC: decided bits plus the bit under trial.
  function automatic logic [RES_W-1:0] trial_code(input logic [RES_W-1:0] code,
                                                  input logic [IDX_W-1:0] idx);
    logic [RES_W-1:0] r;
    r      = code;
    r[idx] = 1'b1;
    return r;
  endfunction

  // Keep the trial bit when the input is at or above the DAC level.
  function automatic logic [RES_W-1:0] decide(input logic [RES_W-1:0] code,
                                              input logic [IDX_W-1:0] idx,
                                              input logic cmp);
    logic [RES_W-1:0] r;
    r      = code;
    r[idx] = cmp;
    return r;
  endfunction

  assign dac_code = bit_phase ? trial_code(work, bit_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work   <= '0;
      result <= '0;
    end else begin
      if (discharge)              work <= '0;
      else if (bit_phase && tick) work <= decide(work, bit_idx, cmp_in);
      if (conv_end)   result <= decide(work, bit_idx, cmp_in);
      else if (sw_wr) result <= sw_data;
    end
  end

  p_result_only_on_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_end && !sw_wr) |=> $stable(result));

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES_W       = 10,
  parameter int ACQ_W       = 3,
  parameter int RECOV_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tad_tick,
  input  logic             ctl_wr,
  input  logic             ctl_on,
  input  logic             ctl_go,
  input  logic [ACQ_W-1:0] ctl_acq,
  input  logic             res_wr,
  input  logic [RES_W-1:0] res_wdata,
  input  logic             flag_clr,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             sample_closed,
  output logic             discharge,
  output logic             adc_on,
  output logic             busy,
  output logic             done_flag,
  output logic [RES_W-1:0] result
);

  localparam int IDX_W = $clog2(RES_W);

  logic             go;
  logic [ACQ_W-1:0] acq_sel;
  logic             abort_evt;
  logic             conv_end;
  logic             conv_active;
  logic             bit_phase;
  logic [IDX_W-1:0] bit_idx;

  assign busy = go;

  sar_ctrl_reg #(.ACQ_W(ACQ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(ctl_wr), .wr_on(ctl_on), .wr_go(ctl_go), .wr_acq(ctl_acq),
    .clr_flag(flag_clr), .conv_active(conv_active), .conv_end(conv_end),
    .adc_on(adc_on), .go(go), .acq_sel(acq_sel),
    .done_flag(done_flag), .abort_evt(abort_evt)
  );

  sar_fsm #(.RES_W(RES_W), .ACQ_W(ACQ_W), .RECOV_TICKS(RECOV_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tad_tick),
    .go(go), .adc_on(adc_on), .acq_sel(acq_sel), .abort_evt(abort_evt),
    .sample_closed(sample_closed), .discharge(discharge),
    .bit_phase(bit_phase), .bit_idx(bit_idx),
    .conv_end(conv_end), .conv_active(conv_active)
  );

  sar_trial #(.RES_W(RES_W)) u_trial (
    .clk(clk), .rst_n(rst_n), .tick(tad_tick), .cmp_in(cmp_in),
    .discharge(discharge), .bit_phase(bit_phase), .bit_idx(bit_idx),
    .conv_end(conv_end), .sw_wr(res_wr), .sw_data(res_wdata),
    .dac_code(dac_code), .result(result)
  );

  p_complete_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |=> (done_flag && !busy && sample_closed));

  p_abort_drops_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!busy && sample_closed));

endmodule

// File: tb/sar_seq_test.sv
module sar_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tad_tick = 1'b0;
  logic       ctl_wr = 1'b0, ctl_on = 1'b0, ctl_go = 1'b0;
  logic [2:0] ctl_acq = 3'd0;
  logic       res_wr = 1'b0;
  logic [9:0] res_wdata = '0;
  logic       flag_clr = 1'b0;
  logic       cmp_in;
  logic [9:0] dac_code, result;
  logic       sample_closed, discharge, adc_on, busy, done_flag;
  logic [9:0] vin = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // Behavioural comparator: high when the input is at or above the DAC level.
  always_comb cmp_in = (vin >= dac_code);

  sar_seq uut (
    .clk(clk), .rst_n(rst_n), .tad_tick(tad_tick),
    .ctl_wr(ctl_wr), .ctl_on(ctl_on), .ctl_go(ctl_go), .ctl_acq(ctl_acq),
    .res_wr(res_wr), .res_wdata(res_wdata), .flag_clr(flag_clr),
    .cmp_in(cmp_in), .dac_code(dac_code), .sample_closed(sample_closed),
    .discharge(discharge), .adc_on(adc_on), .busy(busy),
    .done_flag(done_flag), .result(result)
  );

  function automatic int exp_acq(input int code);
    return (code < 4) ? code * 2 : (code - 2) * 4;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tick1();
    tad_tick = 1'b1;
    cyc();
    tad_tick = 1'b0;
    cyc();
    cyc();
  endtask

  task automatic wr_ctl(input logic on, input logic go, input logic [2:0] acq);
    ctl_wr = 1'b1; ctl_on = on; ctl_go = go; ctl_acq = acq;
    cyc();
    ctl_wr = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    cyc();
    flag_clr = 1'b0;
  endtask

  task automatic finish_conv(output int n);
    n = 0;
    while (busy && n < 60) begin
      tick1();
      n++;
    end
  endtask

  task automatic run_conv(input logic [9:0] v, input int code);
    int n;
    int na;
    na = exp_acq(code);
    tick1(); tick1();
    clear_flag();
    vin = v;
    wr_ctl(1'b1, 1'b1, 3'(code));
    cyc();
    check("R9 busy after start", int'(busy), 1);
    check("R4 discharge before first tick", int'(discharge), (na == 0) ? 1 : 0);
    check("R5 sample before first tick", int'(sample_closed), (na != 0) ? 1 : 0);
    n = 0;
    while (busy && n < 60) begin
      tick1();
      n++;
      if (na > 0 && n == na) begin
        check("R4 discharge after acquisition", int'(discharge), 1);
        check("R5 sample open in discharge", int'(sample_closed), 0);
      end
      if (na > 0 && n < na) check("R2 sample closed in acquisition", int'(sample_closed), 1);
      if (n == na + 1) begin
        check("R13 first trial code", int'(dac_code), 10'h200);
        check("R5 sample open in trials", int'(sample_closed), 0);
      end
      if (n == na + 2)
        check("R13 second trial code", int'(dac_code), int'((v & 10'h200) | 10'h100));
    end
    check("R2 R3 tick count", n, na + 11);
    check("R6 result", int'(result), int'(v));
    check("R6 flag set", int'(done_flag), 1);
    check("R6 sample closed after end", int'(sample_closed), 1);
  endtask

  initial begin
    int n;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1234);
    repeat (4) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 flag", int'(done_flag), 0);
    check("R1 result", int'(result), 0);
    check("R1 sample", int'(sample_closed), 1);
    check("R1 discharge", int'(discharge), 0);
    check("R1 dac", int'(dac_code), 0);
    check("R1 adc_on", int'(adc_on), 0);

    // R9: enabling and starting in one write does nothing
    wr_ctl(1'b1, 1'b1, 3'd0);
    cyc();
    check("R9 no start on enabling write", int'(busy), 0);
    check("R9 converter on", int'(adc_on), 1);
    tick1(); tick1(); tick1();
    check("R9 no discharge", int'(discharge), 0);

    // Directed conversions
    run_conv(10'h3FF, 0);
    repeat (5) cyc();
    check("R10 flag sticky", int'(done_flag), 1);
    clear_flag();
    check("R10 flag cleared", int'(done_flag), 0);
    run_conv(10'h000, 2);
    run_conv(10'h200, 1);
    run_conv(10'h1FF, 7);

    // R8: start right after completion waits two ticks
    wr_ctl(1'b1, 1'b1, 3'd0);
    cyc();
    tick1();
    check("R8 gap after completion, tick 1", int'(discharge), 0);
    tick1();
    check("R8 gap after completion, tick 2", int'(discharge), 1);
    finish_conv(n);
    check("R8 R3 remaining ticks", n, 11);

    // R12: no tick, no progress
    tick1(); tick1();
    wr_ctl(1'b1, 1'b1, 3'd0);
    cyc();
    repeat (10) cyc();
    check("R12 hold in discharge", int'(discharge), 1);
    check("R12 dac idle", int'(dac_code), 0);
    finish_conv(n);

    // R11 / R7: software write, then abort preserves it
    res_wr = 1'b1; res_wdata = 10'h155;
    cyc();
    res_wr = 1'b0;
    check("R11 software write", int'(result), 10'h155);
    tick1(); tick1();
    clear_flag();
    vin = 10'h3FF;
    wr_ctl(1'b1, 1'b1, 3'd1);
    cyc();
    repeat (5) tick1();
    wr_ctl(1'b1, 1'b0, 3'd1);
    check("R7 busy cleared by abort", int'(busy), 0);
    check("R7 R11 result kept", int'(result), 10'h155);
    check("R7 no flag", int'(done_flag), 0);
    check("R5 sample closed after abort", int'(sample_closed), 1);
    wr_ctl(1'b1, 1'b1, 3'd0);
    cyc();
    tick1();
    check("R8 gap after abort, tick 1", int'(discharge), 0);
    tick1();
    check("R8 gap after abort, tick 2", int'(discharge), 1);
    finish_conv(n);
    check("R6 result after abort recovery", int'(result), 10'h3FF);

    // Random conversions
    for (int i = 0; i < 16; i++) begin
      run_conv(10'($urandom % 1024), int'($urandom % 8));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule